// File: doc/BRIEF.md
# Flash Operation Completion Detector

This block watches a parallel NOR flash device while an embedded program or erase runs inside it, and reports when that operation has ended. After a single start pulse it issues a series of reads to one address over a simple read channel. It inspects one status bit of each returned byte, and it stops when that bit shows that the device has settled.

Two detection schemes are offered. In toggle mode the device flips a status bit on every read while it is busy. The block takes a reference read and then re-reads until two successive samples of that bit agree. In polling mode the device returns the complement of the top data bit until the write lands, so the block reads until that bit equals the one it was told to expect. For erase work in toggle mode, the block waits a programmable number of microseconds before each re-read and reads from the device base address. An iteration limit turns a device that never settles into a timeout. A warning flag marks runs that took unusually many iterations.

The read channel carries no back-pressure of its own. A request stays raised with a stable address until the device returns a data-valid strobe, and only one read is in flight at any time. A strobe seen while no request is raised is ignored.

Top module: `flash_done_det`

## Requirements
- R1: While reset is applied and after it is released, `rd_req`, `done`, `timeout` and `warn` are low.
- R2: With `start_poll`=0 (toggle mode), the first read only sets a reference value of data bit 6. Each later read is one comparison. The run ends with `done` at the first comparison whose bit 6 equals the bit 6 of the read just before it, so a run that ends at comparison k makes k+1 reads.
- R3: With `start_poll`=1 (polling mode), every read is one comparison. The run ends with `done` at the first read whose data bit 7 equals bit 7 of `start_data`. All other data bits are ignored, so a run that ends at comparison k makes k reads.
- R4: If MAX_ITER comparisons all fail, `timeout` pulses instead of `done`, and no further read is issued.
- R5: `warn` pulses together with `done` or `timeout` exactly when the run made more than WARN_ITER comparisons. It is never high at any other time.
- R6: In toggle mode with `start_erase`=1, `rd_req` stays low for exactly CLK_PER_US*SLOW_WAIT_US+1 cycles after each data-valid strobe that does not end the run. In every other mode the next request follows the strobe with no idle cycle.
- R7: In toggle mode with `start_erase`=1, every read uses address 0. In all other cases every read uses `start_addr` as captured at the start pulse.
- R8: `rd_req` stays high with `rd_addr` unchanged until `rd_rvalid` is seen. `rd_rvalid` while `rd_req` is low has no effect.
- R9: `done` and `timeout` are single-cycle pulses that are never high together. In the pulse cycle `rd_req` is already low and the block is idle again.
- R10: A start pulse that arrives while a run is in progress is ignored.
- R11: `done` or `timeout` rises in the cycle right after the data-valid strobe of the deciding read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a run when the block is idle |
| start_poll | input | 1 | 0 selects toggle mode, 1 selects polling mode |
| start_erase | input | 1 | In toggle mode: wait before each re-read and read address 0 |
| start_addr | input | ADDR_W | Address to read from |
| start_data | input | DATA_W | Data that was written; bit 7 is the polling target |
| rd_req | output | 1 | Read request, held until `rd_rvalid` |
| rd_addr | output | ADDR_W | Read address, stable while `rd_req` is high |
| rd_rvalid | input | 1 | Read data valid strobe, one cycle per completed read |
| rd_rdata | input | DATA_W | Read data, sampled with `rd_rvalid` |
| done | output | 1 | One-cycle pulse: the operation finished |
| timeout | output | 1 | One-cycle pulse: the iteration limit was reached |
| warn | output | 1 | One-cycle pulse with `done`/`timeout` after a long run |

## Verification
A wrong reference bit or a lost first-read flag shows up at the ports as a run that ends one read early or late. That change in read count, and in the cycle of the `done` pulse, is visible as soon as the run ends. A miscounted iteration register moves the `timeout` and `warn` boundaries by one comparison, so every comparison count is swept across both limits. A wait counter that is off by one shifts the idle gap between strobes in erase runs by one cycle at the first re-read. A mode or address latched at the wrong time shows on `rd_addr` in the very first request.

// File: rtl/fdd_pkg.sv
package fdd_pkg;

  typedef enum logic {
    MODE_TOGGLE = 1'b0,
    MODE_POLL   = 1'b1
  } fdd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WAIT = 2'd2
  } fdd_state_e;

endpackage

// File: rtl/fdd_status_cmp.sv
module fdd_status_cmp
  import fdd_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int TOGGLE_BIT = 6,
  parameter int POLL_BIT   = 7
) (
  input  fdd_mode_e         mode,
  input  logic [DATA_W-1:0] rdata,
  input  logic              prev_bit,
  input  logic              exp_bit,
  output logic              sample_bit,
  output logic              match
);

  logic tog_bit;
  logic pol_bit;
  logic unused_rdata;

  assign tog_bit      = rdata[TOGGLE_BIT];
  assign pol_bit      = rdata[POLL_BIT];
  assign unused_rdata = ^rdata;

  always_comb begin
    if (mode == MODE_TOGGLE) begin
      sample_bit = tog_bit;
      match      = (tog_bit == prev_bit);
    end else begin
      sample_bit = pol_bit;
      match      = (pol_bit == exp_bit);
    end
  end

endmodule

// File: rtl/fdd_wait_timer.sv
module fdd_wait_timer #(
  parameter int CLK_PER_US = 50,
  parameter int WAIT_US    = 8000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic expired
);

  generate
    if (WAIT_US == 0 || CLK_PER_US == 0) begin : g_none
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) expired <= 1'b0;
        else        expired <= arm;
      end
    end else begin : g_cnt
      localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
      localparam int US_W  = (WAIT_US > 1) ? $clog2(WAIT_US) : 1;

      logic             busy_q;
      logic [PRE_W-1:0] pre_q;
      logic [US_W-1:0]  us_q;
      logic             pre_last;
      logic             us_last;

      assign pre_last = (pre_q == PRE_W'(CLK_PER_US - 1));
      assign us_last  = (us_q == US_W'(WAIT_US - 1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          busy_q  <= 1'b0;
          pre_q   <= '0;
          us_q    <= '0;
          expired <= 1'b0;
        end else begin
          expired <= 1'b0;
          if (arm) begin
            busy_q <= 1'b1;
            pre_q  <= '0;
            us_q   <= '0;
          end else if (busy_q) begin
            if (pre_last) begin
              pre_q <= '0;
              if (us_last) begin
                busy_q  <= 1'b0;
                expired <= 1'b1;
              end else begin
                us_q <= us_q + 1'b1;
              end
            end else begin
              pre_q <= pre_q + 1'b1;
            end
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/fdd_iter_ctr.sv
module fdd_iter_ctr #(
  parameter int MAX_ITER  = 32'h0FFF_FFFF,
  parameter int WARN_ITER = 32'h0010_0000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit,
  output logic over_warn
);

  localparam int ITER_W = $clog2(MAX_ITER + 1);

  logic [ITER_W-1:0] cnt_q;

  // this comparison is the MAX_ITER-th one
  assign at_limit  = (cnt_q == ITER_W'(MAX_ITER - 1));
  // this comparison brings the total above WARN_ITER
  assign over_warn = (cnt_q >= ITER_W'(WARN_ITER));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/flash_done_det.sv
module flash_done_det
  import fdd_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int TOGGLE_BIT   = 6,
  parameter int POLL_BIT     = 7,
  parameter int MAX_ITER     = 32'h0FFF_FFFF,
  parameter int WARN_ITER    = 32'h0010_0000,
  parameter int CLK_PER_US   = 50,
  parameter int SLOW_WAIT_US = 8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_poll,
  input  logic              start_erase,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rvalid,
  input  logic [DATA_W-1:0] rd_rdata,
  output logic              done,
  output logic              timeout,
  output logic              warn
);

  fdd_state_e        st_q, st_d;
  fdd_mode_e         mode_q;
  logic              erase_q;
  logic [ADDR_W-1:0] addr_q;
  logic              exp_q;
  logic              prev_q;
  logic              first_q;

  logic accept, resp, compare;
  logic sample_bit, match;
  logic fin_ok, fin_to, go_on;
  logic need_wait, arm, expired;
  logic at_limit, over_warn;
  logic unused_data;

  assign unused_data = ^start_data;

  assign accept    = start && (st_q == ST_IDLE);
  assign resp      = (st_q == ST_READ) && rd_rvalid;
  assign compare   = resp && !first_q;
  assign fin_ok    = compare && match;
  assign fin_to    = compare && !match && at_limit;
  assign go_on     = resp && !fin_ok && !fin_to;
  assign need_wait = (mode_q == MODE_TOGGLE) && erase_q;
  assign arm       = go_on && need_wait;

  fdd_status_cmp #(
    .DATA_W    (DATA_W),
    .TOGGLE_BIT(TOGGLE_BIT),
    .POLL_BIT  (POLL_BIT)
  ) u_cmp (
    .mode      (mode_q),
    .rdata     (rd_rdata),
    .prev_bit  (prev_q),
    .exp_bit   (exp_q),
    .sample_bit(sample_bit),
    .match     (match)
  );

  fdd_iter_ctr #(
    .MAX_ITER (MAX_ITER),
    .WARN_ITER(WARN_ITER)
  ) u_iter (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .inc      (compare),
    .at_limit (at_limit),
    .over_warn(over_warn)
  );

  fdd_wait_timer #(
    .CLK_PER_US(CLK_PER_US),
    .WAIT_US   (SLOW_WAIT_US)
  ) u_wait (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (arm),
    .expired(expired)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = ST_READ;
      ST_READ: begin
        if (fin_ok || fin_to) st_d = ST_IDLE;
        else if (go_on)       st_d = need_wait ? ST_WAIT : ST_READ;
      end
      ST_WAIT: if (expired) st_d = ST_READ;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      mode_q  <= MODE_TOGGLE;
      erase_q <= 1'b0;
      addr_q  <= '0;
      exp_q   <= 1'b0;
      prev_q  <= 1'b0;
      first_q <= 1'b0;
      done    <= 1'b0;
      timeout <= 1'b0;
      warn    <= 1'b0;
    end else begin
      st_q    <= st_d;
      done    <= fin_ok;
      timeout <= fin_to;
      warn    <= (fin_ok || fin_to) && over_warn;
      if (accept) begin
        mode_q  <= start_poll ? MODE_POLL : MODE_TOGGLE;
        erase_q <= start_erase;
        addr_q  <= (!start_poll && start_erase) ? '0 : start_addr;
        exp_q   <= start_data[POLL_BIT];
        first_q <= !start_poll;
      end else if (go_on) begin
        prev_q  <= sample_bit;
        first_q <= 1'b0;
      end
    end
  end

  assign rd_req  = (st_q == ST_READ);
  assign rd_addr = addr_q;

endmodule

// File: rtl/fdd_checker.sv
module fdd_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_rvalid,
  input logic              done,
  input logic              timeout,
  input logic              warn
);

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |=> !(done || timeout)); // R9

  AST_IDLE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |-> !rd_req); // R9

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_rvalid) |=> (rd_req && $stable(rd_addr))); // R8

  AST_END_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |-> $past(rd_req && rd_rvalid)); // R11

  AST_WARN_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    warn |-> (done || timeout)); // R5

endmodule

bind flash_done_det fdd_checker #(.ADDR_W(ADDR_W)) u_fdd_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_req   (rd_req),
  .rd_addr  (rd_addr),
  .rd_rvalid(rd_rvalid),
  .done     (done),
  .timeout  (timeout),
  .warn     (warn)
);

// File: tb/flash_done_det_tb.sv
module flash_done_det_tb;

  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int MAXI     = 12;
  localparam int WARNI    = 5;
  localparam int CPU      = 2;
  localparam int WUS      = 3;
  localparam int WAIT_CYC = CPU * WUS;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              start = 1'b0, start_poll = 1'b0, start_erase = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [DATA_W-1:0] start_data = '0;
  logic              rd_req, rd_rvalid, done, timeout, warn;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_rdata;

  flash_done_det #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOGGLE_BIT(6), .POLL_BIT(7),
    .MAX_ITER(MAXI), .WARN_ITER(WARNI), .CLK_PER_US(CPU), .SLOW_WAIT_US(WUS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_poll(start_poll),
    .start_erase(start_erase), .start_addr(start_addr), .start_data(start_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
    .done(done), .timeout(timeout), .warn(warn)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // flash read model
  logic [7:0]        seq   [0:63];
  int                stamp [0:63];
  logic [ADDR_W-1:0] alog  [0:63];
  int   rd_idx = 0, job_base = 0, lat = 0, lat_cnt = 0;
  logic mdl_rv = 1'b0, spur = 1'b0;
  logic [7:0] mdl_data = 8'h00;

  assign rd_rvalid = mdl_rv | spur;
  assign rd_rdata  = mdl_data;

  always @(posedge clk) begin
    mdl_rv <= 1'b0;
    if (rd_req && !mdl_rv) begin
      if (lat_cnt >= lat) begin
        mdl_rv   <= 1'b1;
        mdl_data <= seq[(rd_idx - job_base) & 63];
        stamp[(rd_idx - job_base) & 63] <= cyc;
        alog[(rd_idx - job_base) & 63]  <= rd_addr;
        rd_idx   <= rd_idx + 1;
        lat_cnt  <= 0;
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end else begin
      lat_cnt <= 0;
    end
  end

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (cyc == 150000) begin
      total++;
      bad++;
      $display("FAIL R11 watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // k = comparison that matches; k > MAXI means no comparison matches
  task automatic run_job(input bit poll, input bit erase, input logic [15:0] addr,
                         input logic [7:0] data, input int l, input int k, input bit twice);
    bit   exp_to, exp_warn, dn, to, wn, rq;
    int   comps, reads, gap, n, c, nreads, bad_addr, bad_gap, idx0;
    logic [15:0] eaddr;
    string rq_tag;
    exp_to   = (k > MAXI);
    comps    = exp_to ? MAXI : k;
    reads    = comps + (poll ? 0 : 1);
    exp_warn = (comps > WARNI);
    eaddr    = (!poll && erase) ? 16'h0000 : addr;
    gap      = l + 2 + ((!poll && erase) ? WAIT_CYC + 1 : 0);
    rq_tag   = poll ? "R3" : "R2";
    for (int i = 0; i < 64; i++) begin
      logic [7:0] f;
      logic       b;
      f = 8'(i * 53 + int'(addr) + k);
      if (!poll) begin
        b = (i < k) ? i[0] : 1'((k - 1) % 2);
        seq[i] = {f[7], b, f[5:0]};
      end else begin
        b = (i < k - 1) ? ~data[7] : data[7];
        seq[i] = {b, f[6:0]};
      end
    end
    @(negedge clk);
    job_base    = rd_idx;
    lat         = l;
    start       = 1'b1;
    start_poll  = poll;
    start_erase = erase;
    start_addr  = addr;
    start_data  = data;
    @(negedge clk);
    start = 1'b0;
    if (twice) begin
      start       = 1'b1;
      start_poll  = ~poll;
      start_erase = ~erase;
      start_addr  = ~addr;
      start_data  = ~data;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && !timeout && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 3000, "R11", "run finished", n, 0);
    if (n >= 3000) return;
    dn = done; to = timeout; wn = warn; rq = rd_req; c = cyc;
    nreads = rd_idx - job_base;
    chk(dn == !exp_to, rq_tag, "done pulse", int'(dn), int'(!exp_to));
    chk(to == exp_to, "R4", "timeout pulse", int'(to), int'(exp_to));
    chk(wn == exp_warn, "R5", "warn flag", int'(wn), int'(exp_warn));
    chk(!rq, "R9", "rd_req low at end", int'(rq), 0);
    chk(nreads == reads, exp_to ? "R4" : rq_tag, "read count", nreads, reads);
    idx0 = (nreads > 0) ? nreads - 1 : 0;
    chk(c == stamp[idx0] + 2, "R11", "end pulse cycle", c, stamp[idx0] + 2);
    bad_addr = 0;
    bad_gap  = 0;
    for (int i = 0; i < nreads && i < 64; i++) begin
      if (alog[i] != eaddr) bad_addr++;
      if (i > 0 && stamp[i] - stamp[i-1] != gap) bad_gap++;
    end
    chk(bad_addr == 0, twice ? "R10" : "R7", "read address", bad_addr, 0);
    chk(bad_gap == 0, "R6", "gaps between reads", bad_gap, 0);
    @(negedge clk);
    chk(!done && !timeout && !warn, "R9", "pulse one cycle",
        int'({done, timeout, warn}), 0);
    repeat (4) @(negedge clk);
    chk(rd_idx - job_base == nreads && !rd_req, "R4", "no read after end",
        rd_idx - job_base, nreads);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!rd_req && !done && !timeout && !warn, "R1", "outputs in reset",
        int'({rd_req, done, timeout, warn}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!rd_req && !done && !timeout && !warn, "R1", "outputs after reset",
        int'({rd_req, done, timeout, warn}), 0);

    // R8: a strobe without a request changes nothing
    spur = 1'b1;
    repeat (3) @(negedge clk);
    spur = 1'b0;
    @(negedge clk);
    chk(!rd_req && !done && !timeout && !warn, "R8", "stray strobe ignored",
        int'({rd_req, done, timeout, warn}), 0);

    for (int p = 0; p < 2; p++) begin
      for (int e = 0; e < 2; e++) begin
        for (int k = 1; k <= MAXI + 1; k++) begin
          run_job(p[0], e[0], 16'(16'h1230 + k * 7), 8'(k * 29 + p * 128), k % 3, k, 1'b0);
        end
      end
    end

    // R10: second start during a run
    run_job(1'b0, 1'b0, 16'h5A5A, 8'h3C, 2, 3, 1'b1);
    run_job(1'b1, 1'b0, 16'h0F0F, 8'h80, 1, 4, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule